// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two 32-bit integers over 32 clock cycles using a single adder that is one bit wider than an operand. A one-cycle `start` pulse captures the multiplicand `a`, the multiplier `b` and the mode bit `is_signed`. The 64-bit product builds up in a pair of registers, `hi` and `lo`. The multiplier is loaded straight into `lo`, and its bits are consumed from the bottom while product bits are shifted in from the top. There is no separate multiplier register.

Each cycle, the adder adds the multiplicand to `hi` or leaves `hi` unchanged, depending on the current low bit of `lo`. The whole pair then moves right by one place, and the adder's extra top bit enters `hi` from above. In unsigned mode that top bit is the carry. In two's-complement mode both adder inputs are sign-extended, so the top bit is the sign. In that mode the last step subtracts the multiplicand instead of adding it, because the multiplier's top bit has negative weight.

When the 32 steps are over, `done` pulses for one cycle. The product then stays on `hi`/`lo` until the next accepted start.

Top module: `shift_add_mul`

## Requirements
- R1: While `rst_n` is low, and immediately after reset, `busy`, `done`, `hi` and `lo` are all 0.
- R2: A `start` high at a rising edge while `busy` is low is accepted. From the next cycle `busy` is 1, `hi` is 0 and `lo` holds the captured `b`.
- R3: `done` is 1 for exactly one cycle, right after the 32nd rising edge that follows the accepting edge. `busy` falls on that same edge.
- R4: With `is_signed`=0 at acceptance, {`hi`,`lo`} equals the unsigned 64-bit product of `a` and `b`.
- R5: With `is_signed`=1 at acceptance, {`hi`,`lo`} equals the 64-bit two's-complement product of `a` and `b`.
- R6: The small cases hold: unsigned 12 × 13 = 156, and signed −4 × −3 = +12.
- R7: A `start` while `busy` is 1 is ignored. The running product and its completion cycle are unchanged.
- R8: While idle and not starting, `hi` and `lo` keep their values.
- R9: The extreme operands give exact results:
  - signed min × min = 2^62
  - signed min × −1 = 2^31
  - unsigned all-ones × all-ones = 2^64 − 2^33 + 1
  - any operand × 0 = 0
- R10: Changes on `a`, `b` and `is_signed` after the accepting edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a multiply when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| a | input | 32 | Multiplicand |
| b | input | 32 | Multiplier |
| busy | output | 1 | A multiply is in progress |
| done | output | 1 | One-cycle completion pulse |
| hi | output | 32 | Upper product half |
| lo | output | 32 | Lower product half |

## Verification
Most internal faults in this block only become visible when `done` rises, 32 cycles after acceptance:
- An adder that mishandles the carry or sign bit corrupts `hi` at that point.
- A final step that adds instead of subtracting corrupts `hi` at that point.
- A skipped or extra shift misaligns both halves at that point.

A miscounted iteration counter is exposed earlier: `done` arrives in the wrong cycle, which the bench measures edge by edge. A mode bit or multiplicand that is not latched shows up only when the operand ports are disturbed during a run, so the bench changes them mid-operation.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mul_state_e;
endpackage

// File: rtl/mul_addsub.sv
// Width+1 adder: extends both inputs (zero or sign), optionally gates
// the addend to zero and optionally subtracts it.
module mul_addsub #(
  parameter int W = 32
) (
  input  logic         sgn,
  input  logic         en,
  input  logic         sub,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W:0]   sum
);
  logic [W:0] ext_x;
  logic [W:0] ext_y;

  always_comb begin
    ext_x = {sgn & x[W-1], x};
    ext_y = en ? {sgn & y[W-1], y} : '0;
    sum   = sub ? (ext_x - ext_y) : (ext_x + ext_y);
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic load,
  output logic last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST_IDX = CW'(W - 1);

  mul_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  assign busy = (state_q == ST_RUN);
  assign load = start & (state_q == ST_IDLE);
  assign last = busy & (cnt_q == LAST_IDX);
  assign done = done_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        if (cnt_q == LAST_IDX) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mul_datapath.sv
module mul_datapath #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         last,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic [W-1:0] hi_q, hi_d;
  logic [W-1:0] lo_q, lo_d;
  logic [W-1:0] mcand_q, mcand_d;
  logic         sgn_q, sgn_d;
  logic         do_sub;
  logic [W:0]   sum;

  assign do_sub = sgn_q & last & lo_q[0];

  mul_addsub #(.W(W)) u_addsub (
    .sgn (sgn_q),
    .en  (lo_q[0]),
    .sub (do_sub),
    .x   (hi_q),
    .y   (mcand_q),
    .sum (sum)
  );

  always_comb begin
    hi_d    = hi_q;
    lo_d    = lo_q;
    mcand_d = mcand_q;
    sgn_d   = sgn_q;
    if (load) begin
      hi_d    = '0;
      lo_d    = b;
      mcand_d = a;
      sgn_d   = is_signed;
    end else if (step) begin
      hi_d = sum[W:1];
      lo_d = {sum[0], lo_q[W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
      sgn_q   <= 1'b0;
    end else begin
      if (load || step) begin
        hi_q <= hi_d;
        lo_q <= lo_d;
      end
      if (load) begin
        mcand_q <= mcand_d;
        sgn_q   <= sgn_d;
      end
    end
  end

  assign hi = hi_q;
  assign lo = lo_q;

  p_load_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (hi_q == '0 && lo_q == $past(b)));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> ($stable(hi_q) && $stable(lo_q)));
  p_operands_latched_r10: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> $stable(mcand_q));
endmodule

// File: rtl/shift_add_mul.sv
module shift_add_mul #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] hi,
  output logic [W-1:0] lo
);
  logic load;
  logic last;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .load  (load),
    .last  (last)
  );

  mul_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (busy),
    .last      (last),
    .is_signed (is_signed),
    .a         (a),
    .b         (b),
    .hi        (hi),
    .lo        (lo)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done));
  p_done_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(hi) && $stable(lo)));
endmodule

// File: tb/sim_shift_add_mul.sv
`timescale 1ns/1ps
module sim_shift_add_mul;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        is_signed;
  logic [31:0] a, b;
  logic        busy, done;
  logic [31:0] hi, lo;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  shift_add_mul u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .a(a), .b(b), .busy(busy), .done(done), .hi(hi), .lo(lo)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] x, input logic [31:0] y,
                                          input logic s);
    logic [63:0] ex, ey;
    if (s) begin
      ex = {{32{x[31]}}, x};
      ey = {{32{y[31]}}, y};
    end else begin
      ex = {32'b0, x};
      ey = {32'b0, y};
    end
    return ex * ey;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // disturb=1 pulses start while busy (R7) and changes a, b, is_signed mid-run (R10)
  task automatic run_op(input logic [31:0] x, input logic [31:0] y, input logic s,
                        input string req, input bit disturb);
    logic [63:0] expv;
    int n;
    expv = ref_mul(x, y, s);
    @(negedge clk);
    a = x; b = y; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy", {63'b0, busy}, 64'd1);
    n = 0;
    while (n < 40) begin
      @(negedge clk);
      n++;
      if (disturb && n == 5) begin
        start = 1'b1; a = ~x; b = x ^ y; is_signed = ~s;
      end
      if (disturb && n == 6) start = 1'b0;
      if (done) break;
    end
    check("R3 latency", 64'(n), 64'd32);
    check("R3 busy low at done", {63'b0, busy}, 64'd0);
    check(req, {hi, lo}, expv);
    if (disturb) check("R7 R10 result", {hi, lo}, expv);
    @(negedge clk);
    check("R3 one-cycle done", {63'b0, done}, 64'd0);
    check("R8 hold", {hi, lo}, expv);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; a = '0; b = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {30'b0, busy, done, hi}, 64'd0);
    check("R1 reset lo", {32'b0, lo}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", {30'b0, busy, done, hi}, 64'd0);

    run_op(32'd12, 32'd13, 1'b0, "R6 unsigned 12x13", 1'b0);
    run_op(32'hFFFF_FFFC, 32'hFFFF_FFFD, 1'b1, "R6 signed -4x-3", 1'b0);
    run_op(32'h8000_0000, 32'h8000_0000, 1'b1, "R9 min*min", 1'b0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 1'b1, "R9 min*-1", 1'b0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R9 umax*umax", 1'b0);
    run_op(32'hDEAD_BEEF, 32'd0, 1'b1, "R9 x*0", 1'b0);
    run_op(32'd0, 32'hFFFF_FFFF, 1'b0, "R9 0*x", 1'b0);
    run_op(32'hFFFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R5 -1*max", 1'b0);
    run_op(32'h1234_5678, 32'h8765_4321, 1'b1, "R5 R7 R10 disturbed signed", 1'b1);
    run_op(32'h8765_4321, 32'hF0F0_0F0F, 1'b0, "R4 R7 R10 disturbed unsigned", 1'b1);

    // R8: idle with changing operand ports, no start
    held = {hi, lo};
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a = $urandom; b = $urandom; is_signed = ~is_signed;
    end
    @(negedge clk);
    check("R8 idle hold", {hi, lo}, held);

    for (int i = 0; i < 30; i++) begin
      run_op($urandom, $urandom, 1'b0, "R4 random unsigned", (i % 7) == 3);
      run_op($urandom, $urandom, 1'b1, "R5 random signed", (i % 5) == 2);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule